// File: doc/BRIEF.md
# Bufferless Deflection Mesh Switch

This block is one switch node of a two-dimensional mesh network-on-chip. It has one input link and one output link towards each of its four neighbours (north, east, south and west). Each link carries a whole packet in parallel together with a valid flag. The switch holds no packets. Every cycle it gives each arriving packet exactly one output port and registers all four outputs, so every packet leaves one cycle after it arrives.

Each packet header carries the destination column and row and an age count. The switch knows its own column and row through static parameters. It compares them with the destination to find at most two productive directions. Packets are served oldest first, and a packet whose productive outputs are already taken is deflected onto a free port rather than held. Each packet's age is raised on every hop, so a packet that keeps losing gains priority until it wins.

Top module: `defl_router`

## Requirements
- R1: While `rst_n` is low, all four `out_valid` bits are 0. Reset acts asynchronously: `out_valid` clears as soon as `rst_n` falls.
- R2: The header fields are destination X in bits [XW-1:0], destination Y in bits [XW+YW-1:XW] and age in the AW bits above them. Port indices are north=0, east=1, south=2, west=3. X greater than the own X is productive east and X smaller is productive west. Y greater than the own Y is productive north and Y smaller is productive south. A packet with no contention leaves on its X-productive port if it has one, otherwise on its Y-productive port.
- R3: A packet presented on an input appears on its output at the first rising clock edge after it is presented, and not before.
- R4: Each valid input gets exactly one output. No two packets share an output, and the number of valid outputs equals the number of valid inputs in the previous cycle.
- R5: Packets are allocated in order of decreasing age. Among equal ages the lower input index goes first.
- R6: If a packet's first productive output is taken, its second productive output is used when free. If neither is free, the packet takes the lowest-numbered free output.
- R7: Each forwarded packet's age is one higher than on input and saturates at its all-ones value.
- R8: Apart from the age field, every bit of a forwarded packet is output unchanged.
- R9: A packet whose destination equals the switch's own position has no productive direction. It takes the lowest-numbered output still free when its turn comes.
- R10: An output with no packet assigned has `out_valid` at 0, and an idle input cycle yields no valid output. Invalid inputs never take an output, whatever their header fields hold.
- R11: The packet bus of an output that is not valid holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Input packet valid flag, one per neighbour link |
| in_pkt | input | 4*PKT_W | Input packets; link i occupies bits [i*PKT_W +: PKT_W] |
| out_valid | output | 4 | Registered output valid flag, one per neighbour link |
| out_pkt | output | 4*PKT_W | Registered output packets; link p occupies bits [p*PKT_W +: PKT_W] |

## Verification
Every routed packet and every valid flag appears exactly one rising edge after its input is presented. The bench therefore drives each input set on a falling edge and checks the outputs at the next falling edge, half a period after the capturing edge. A separate check samples just before that edge to confirm that nothing arrives early. Reset acts asynchronously and is checked one nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int NP = 4;
  localparam int IW = $clog2(NP);
  localparam int P_N = 0;
  localparam int P_E = 1;
  localparam int P_S = 2;
  localparam int P_W = 3;
  typedef logic [IW-1:0] port_idx_t;
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
  import defl_pkg::*;
#(
  parameter int XW   = 4,
  parameter int YW   = 4,
  parameter int MY_X = 5,
  parameter int MY_Y = 5
) (
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic [NP-1:0] pref_a,
  output logic [NP-1:0] pref_b
);
  localparam logic [XW-1:0] OWN_X = MY_X[XW-1:0];
  localparam logic [YW-1:0] OWN_Y = MY_Y[YW-1:0];

  logic [NP-1:0] xdir, ydir;

  always_comb begin
    xdir = '0;
    ydir = '0;
    if (dst_x > OWN_X)      xdir[P_E] = 1'b1;
    else if (dst_x < OWN_X) xdir[P_W] = 1'b1;
    if (dst_y > OWN_Y)      ydir[P_N] = 1'b1;
    else if (dst_y < OWN_Y) ydir[P_S] = 1'b1;
    // column first, then row
    pref_a = (|xdir) ? xdir : ydir;
    pref_b = (|xdir) ? ydir : '0;
  end
endmodule

// File: rtl/defl_age_rank.sv
module defl_age_rank
  import defl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [NP-1:0]         vld,
  input  logic [NP*AW-1:0]      age,
  output logic [NP-1:0][IW-1:0] rank
);
  // key: valid packets before invalid ones, then older first
  logic [NP-1:0][AW:0] key;

  always_comb begin
    for (int i = 0; i < NP; i++) key[i] = {vld[i], age[i*AW +: AW]};
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic [IW-1:0] cnt;
      cnt = '0;
      for (int j = 0; j < NP; j++) begin
        if (j != i) begin
          if ((key[j] > key[i]) || ((key[j] == key[i]) && (j < i)))
            cnt = cnt + 1'b1;
        end
      end
      rank[i] = cnt;
    end
  end
endmodule

// File: rtl/defl_port_alloc.sv
module defl_port_alloc
  import defl_pkg::*;
(
  input  logic [NP-1:0]         vld,
  input  logic [NP-1:0][IW-1:0] rank,
  input  logic [NP-1:0][NP-1:0] pref_a,
  input  logic [NP-1:0][NP-1:0] pref_b,
  output logic [NP-1:0]         grant_vld,
  output logic [NP-1:0][IW-1:0] grant_src
);
  logic [NP-1:0] free;
  logic [NP-1:0] cand_a, cand_b, pick;

  always_comb begin
    free      = '1;
    grant_vld = '0;
    grant_src = '0;
    cand_a    = '0;
    cand_b    = '0;
    pick      = '0;
    for (int k = 0; k < NP; k++) begin
      for (int i = 0; i < NP; i++) begin
        if (vld[i] && (rank[i] == IW'(k))) begin
          cand_a = pref_a[i] & free;
          cand_b = pref_b[i] & free;
          if (|cand_a)      pick = cand_a;
          else if (|cand_b) pick = cand_b;
          else              pick = free & (~free + 1'b1);
          for (int p = 0; p < NP; p++) begin
            if (pick[p]) begin
              grant_vld[p] = 1'b1;
              grant_src[p] = IW'(i);
            end
          end
          free = free & ~pick;
        end
      end
    end
  end
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter int PKT_W = 128,
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int AW    = 4,
  parameter int MY_X  = 5,
  parameter int MY_Y  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP-1:0]       in_valid,
  input  logic [NP*PKT_W-1:0] in_pkt,
  output logic [NP-1:0]       out_valid,
  output logic [NP*PKT_W-1:0] out_pkt
);
  localparam int DX_LO  = 0;
  localparam int DY_LO  = XW;
  localparam int AGE_LO = XW + YW;
  localparam logic [AW-1:0] AGE_MAX = '1;

  logic [NP-1:0][PKT_W-1:0] fwd_pkt;
  logic [NP*AW-1:0]         age_bus;
  logic [NP-1:0][NP-1:0]    pref_a, pref_b;
  logic [NP-1:0][IW-1:0]    rank;
  logic [NP-1:0]            grant_vld;
  logic [NP-1:0][IW-1:0]    grant_src;
  logic [NP-1:0]            nxt_vld;
  logic [NP-1:0][PKT_W-1:0] nxt_pkt;
  logic [NP-1:0]            vld_q;
  logic [NP-1:0][PKT_W-1:0] pkt_q;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [PKT_W-1:0] pkt;
    logic [AW-1:0]    age;
    logic [AW-1:0]    age_up;

    assign pkt = in_pkt[i*PKT_W +: PKT_W];
    assign age = pkt[AGE_LO +: AW];
    assign age_bus[i*AW +: AW] = age;

    defl_route_calc #(
      .XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)
    ) u_route (
      .dst_x (pkt[DX_LO +: XW]),
      .dst_y (pkt[DY_LO +: YW]),
      .pref_a(pref_a[i]),
      .pref_b(pref_b[i])
    );

    always_comb begin
      age_up = (age == AGE_MAX) ? AGE_MAX : age + 1'b1;
      fwd_pkt[i] = pkt;
      fwd_pkt[i][AGE_LO +: AW] = age_up;
    end
  end

  defl_age_rank #(.AW(AW)) u_rank (
    .vld (in_valid),
    .age (age_bus),
    .rank(rank)
  );

  defl_port_alloc u_alloc (
    .vld      (in_valid),
    .rank     (rank),
    .pref_a   (pref_a),
    .pref_b   (pref_b),
    .grant_vld(grant_vld),
    .grant_src(grant_src)
  );

  // next-state
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      nxt_vld[p] = grant_vld[p];
      nxt_pkt[p] = fwd_pkt[grant_src[p]];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= nxt_vld;
  end

  for (genvar p = 0; p < NP; p++) begin : g_out
    always_ff @(posedge clk) begin
      if (nxt_vld[p]) pkt_q[p] <= nxt_pkt[p];
    end
    assign out_pkt[p*PKT_W +: PKT_W] = pkt_q[p];
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk
  import defl_pkg::*;
#(
  parameter int PKT_W = 128,
  parameter int XW    = 4,
  parameter int YW    = 4,
  parameter int AW    = 4,
  parameter int MY_X  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NP-1:0]       in_valid,
  input logic [NP*PKT_W-1:0] in_pkt,
  input logic [NP-1:0]       out_valid,
  input logic [NP*PKT_W-1:0] out_pkt
);
  localparam int AGE_LO = XW + YW;
  localparam logic [XW-1:0] OWN_X = MY_X[XW-1:0];

  logic                     armed;
  logic [NP-1:0]            in_vld_d;
  logic [NP-1:0][PKT_W-1:0] in_pkt_d;
  logic [NP-1:0][NP-1:0]    hit;

  function automatic logic [PKT_W-1:0] bump(input logic [PKT_W-1:0] pk);
    logic [PKT_W-1:0] r;
    logic [AW-1:0]    a;
    a = pk[AGE_LO +: AW];
    r = pk;
    r[AGE_LO +: AW] = (&a) ? a : a + 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    in_vld_d <= in_valid;
    for (int i = 0; i < NP; i++) in_pkt_d[i] <= in_pkt[i*PKT_W +: PKT_W];
  end

  always_comb begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NP; i++)
        hit[p][i] = in_vld_d[i] && (out_pkt[p*PKT_W +: PKT_W] == bump(in_pkt_d[i]));
  end

  a_r4_conserve: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $countones(out_valid) == $past($countones(in_valid)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |=> (out_valid == '0));

  a_r2_lone_east: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_valid == 4'b0001) && (in_pkt[XW-1:0] > OWN_X)) |=> out_valid[P_E]);

  for (genvar p = 0; p < NP; p++) begin : g_p
    a_r8_forwarded_copy: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_valid[p] |-> (|hit[p]));
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !out_valid[p] |-> $stable(out_pkt[p*PKT_W +: PKT_W]));
  end
endmodule

bind defl_router defl_router_chk #(
  .PKT_W(PKT_W), .XW(XW), .YW(YW), .AW(AW), .MY_X(MY_X)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_pkt   (in_pkt),
  .out_valid(out_valid),
  .out_pkt  (out_pkt)
);

// File: tb/defl_router_tb.sv
module defl_router_tb;
  localparam int PKT_W = 128;
  localparam int NP    = 4;
  localparam int NV    = 11;

  logic                clk;
  logic                rst_n;
  logic [NP-1:0]       in_valid;
  logic [NP*PKT_W-1:0] in_pkt;
  logic [NP-1:0]       out_valid;
  logic [NP*PKT_W-1:0] out_pkt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  defl_router #(.PKT_W(PKT_W), .XW(4), .YW(4), .AW(4), .MY_X(5), .MY_Y(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_pkt(out_pkt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // entry: mask[63:60], header of input i at [12+12*i +: 12] = {age,dy,dx},
  // expected source for output p at [3*p +: 3] (4 = no packet). Node at (5,5).
  localparam logic [63:0] TBL [NV] = '{
    {4'b0001, 12'h000, 12'h000, 12'h000, 12'h059, 3'd4, 3'd4, 3'd0, 3'd4}, // R2 east
    {4'b0100, 12'h000, 12'h051, 12'h000, 12'h000, 3'd2, 3'd4, 3'd4, 3'd4}, // R2 west
    {4'b1010, 12'h095, 12'h000, 12'h015, 12'h000, 3'd4, 3'd1, 3'd4, 3'd3}, // R2 north+south
    {4'b0011, 12'h000, 12'h000, 12'h099, 12'h099, 3'd4, 3'd4, 3'd0, 3'd1}, // R6 second choice
    {4'b1001, 12'h559, 12'h000, 12'h000, 12'h159, 3'd4, 3'd4, 3'd3, 3'd0}, // R5 age wins
    {4'b1111, 12'h259, 12'h259, 12'h259, 12'h259, 3'd3, 3'd2, 3'd0, 3'd1}, // R5 tie by index
    {4'b0100, 12'h000, 12'h055, 12'h000, 12'h000, 3'd4, 3'd4, 3'd4, 3'd2}, // R9 local
    {4'b0101, 12'h000, 12'h055, 12'h000, 12'h395, 3'd4, 3'd4, 3'd2, 3'd0}, // R9 local deflected
    {4'b0010, 12'h000, 12'h000, 12'hF15, 12'h000, 3'd4, 3'd1, 3'd4, 3'd4}, // R7 saturate
    {4'b1111, 12'h911, 12'h795, 12'h751, 12'h051, 3'd3, 3'd0, 3'd2, 3'd1}, // R6 full load
    {4'b0000, 12'h000, 12'h000, 12'h000, 12'h959, 3'd4, 3'd4, 3'd4, 3'd4}  // R10 idle
  };

  function automatic logic [PKT_W-1:0] mk(input logic [11:0] f, input int v, input int i);
    return {32'(v), 32'(i), 52'h5A5A5A5A5A5A5, f};
  endfunction

  function automatic logic [PKT_W-1:0] fwd(input logic [PKT_W-1:0] pk);
    logic [PKT_W-1:0] r;
    r = pk;
    r[11:8] = (pk[11:8] == 4'hF) ? 4'hF : pk[11:8] + 4'h1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [PKT_W-1:0] act,
                     input logic [PKT_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int v);
    logic [63:0] e;
    e = TBL[v];
    in_valid = e[63:60];
    for (int i = 0; i < NP; i++) in_pkt[i*PKT_W +: PKT_W] = mk(e[12+12*i +: 12], v, i);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP*PKT_W-1:0] sent;
    rst_n = 1'b0;
    in_valid = '0;
    in_pkt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == '0, "R1 reset", PKT_W'(out_valid), '0);
    rst_n = 1'b1;

    // vector table, one result per output port
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      apply(v);
      sent = in_pkt;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        logic [2:0] src;
        src = TBL[v][3*p +: 3];
        if (src == 3'd4) begin
          chk(out_valid[p] == 1'b0, "R10 R4 unused output", PKT_W'(out_valid[p]), '0);
        end else begin
          chk(out_valid[p] == 1'b1, "R2 R4 R5 R6 R9 output valid", PKT_W'(out_valid[p]), 1);
          chk(out_pkt[p*PKT_W +: PKT_W] == fwd(sent[src*PKT_W +: PKT_W]),
              "R7 R8 forwarded packet", out_pkt[p*PKT_W +: PKT_W],
              fwd(sent[src*PKT_W +: PKT_W]));
        end
      end
      in_valid = '0;
    end

    // R3: nothing before the capturing edge, packet right after it
    @(negedge clk);
    in_valid = 4'b1000;
    in_pkt[3*PKT_W +: PKT_W] = mk(12'h015, 77, 3);
    sent = in_pkt;
    #9;
    chk(out_valid == '0, "R3 not early", PKT_W'(out_valid), '0);
    @(posedge clk);
    #5;
    chk(out_valid == 4'b0100, "R3 one edge", PKT_W'(out_valid), PKT_W'(4'b0100));
    chk(out_pkt[2*PKT_W +: PKT_W] == fwd(sent[3*PKT_W +: PKT_W]), "R3 data",
        out_pkt[2*PKT_W +: PKT_W], fwd(sent[3*PKT_W +: PKT_W]));

    // R11: idle outputs keep their data
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    chk(out_pkt[2*PKT_W +: PKT_W] == fwd(sent[3*PKT_W +: PKT_W]), "R11 hold",
        out_pkt[2*PKT_W +: PKT_W], fwd(sent[3*PKT_W +: PKT_W]));

    // R1: asynchronous clear while outputs are busy
    apply(5);
    @(negedge clk);
    chk(out_valid == 4'b1111, "R4 all busy", PKT_W'(out_valid), PKT_W'(4'b1111));
    rst_n = 1'b0;
    #1;
    chk(out_valid == '0, "R1 async clear", PKT_W'(out_valid), '0);
    in_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1 after release", PKT_W'(out_valid), '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule